// File: doc/BRIEF.md
# Paced Serial Host Port

This block is a serial peripheral port that works either as the clock-driving master or as a selected slave on a four-wire serial bus. The role comes from one mode input. Words are 8, 16 or 24 bits long, shifted most significant bit first. The clock idles low, data is sampled on the rising edge and changed on the falling edge.

An active-low request line paces the traffic one word at a time. As a slave, the port pulls the line low when it holds a word to send and has room to receive one. The line goes high again once the remote master begins clocking. As a master, the port watches the same line coming from a remote slave. It starts a word only while that line is low, and it starts the next word only after the line has gone high and then low again.

A master that sees its own select input pulled low treats this as a bus conflict. It raises a sticky error flag and drops the word in progress. Software loads a one-word transmit buffer and reads a one-word receive register, using two flags that show when each side is ready.

Top module: `spi_req_port`

## Requirements
- R1: Bits travel MSB first. `len_sel_i` picks the word length: 00 gives 8 bits, 01 gives 16 bits, 10 or 11 gives 24 bits. Transmit and receive words are right-aligned in their 24-bit fields. Received bits above the word length read as zero.
- R2: In master mode the port drives `sck_o`, which idles low. Each high phase and each low phase lasts `clk_div_i`+1 system clocks. `sck_oe_o` is high only while a word is in flight, and `sck_o` is low whenever `sck_oe_o` is low.
- R3: A master starts a word only when all of these hold: `req_ni` is low, a word is loaded for sending, `rx_full_o` is clear and `bus_err_o` is clear.
- R4: After each word, a master does not start another until it has seen `req_ni` high and then low again.
- R5: In slave mode, while `ss_ni` is high, `miso_oe_o` is low and edges on `sck_i` shift no bits and advance no count.
- R6: In slave mode, `req_no` is low between words whenever a word is loaded for sending and `rx_full_o` is clear. It goes high within a few system clocks of the first rising `sck_i` edge of the word.
- R7: `req_oe_o` is low during reset, in master mode, and whenever both bits of `req_en_i` are zero. Otherwise it is high.
- R8: In master mode, a low `ss_ni` sets `bus_err_o`. The flag stays set until `err_clr_i` is pulsed while the conflict is gone. While the flag is set, the word in flight is dropped and `sck_oe_o` stays low.
- R9: `tx_empty_o` is low from a `tx_load_i` pulse until the buffered word moves into the shifter. `rx_full_o` is set when a whole word has been received and is cleared by `rx_read_i`.
- R10: At reset, `tx_empty_o`=1, `rx_full_o`=0, `bus_err_o`=0, `sck_oe_o`=0, `req_oe_o`=0 and `req_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects the master role, 0 the slave role |
| len_sel_i | input | 2 | Word length select |
| clk_div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| req_en_i | input | 2 | Request pin enable bits |
| tx_data_i | input | 24 | Word to send, right-aligned |
| tx_load_i | input | 1 | Writes `tx_data_i` into the transmit buffer |
| tx_empty_o | output | 1 | Transmit buffer may be loaded |
| rx_data_o | output | 24 | Last received word, right-aligned |
| rx_full_o | output | 1 | A received word is waiting |
| rx_read_i | input | 1 | Clears `rx_full_o` |
| bus_err_o | output | 1 | Sticky select conflict flag |
| err_clr_i | input | 1 | Clears `bus_err_o` |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Drive enable for `sck_o` |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | Drive enable for `mosi_o` |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | Drive enable for `miso_o` |
| ss_ni | input | 1 | Slave select, active low |
| req_ni | input | 1 | Request from remote slave, active low |
| req_no | output | 1 | Request to remote master, active low |
| req_oe_o | output | 1 | Drive enable for `req_no` |

## Verification
The assertions check these rules on every cycle:
- the serial clock stays low whenever it is not driven;
- the slave data line is released while select is high;
- the request pin is released in master mode;
- the error flag is sticky and, once it has settled, keeps the clock stopped;
- a load always empties the transmit flag;
- a master word starts only from a legal state.

Other behaviour can only be shown by the bench scenarios, which act as the remote device:
- bit order and alignment for each word length;
- phase lengths under several divider values;
- re-arming on a new request edge;
- clocks ignored while deselected;
- the timing of the slave request around the first edge;
- recovery after an aborted word.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
  localparam int WORD_MAX = 24;
  localparam int CNT_W    = 5;

  typedef enum logic [1:0] {
    LEN_8  = 2'b00,
    LEN_16 = 2'b01,
    LEN_24 = 2'b10
  } len_e;

  function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] sel);
    case (sel)
      LEN_8:   return CNT_W'(8);
      LEN_16:  return CNT_W'(16);
      default: return CNT_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
  parameter int           N       = 1,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g > 0) ? g-1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_req_clkgen.sv
module spi_req_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             busy_q, sck_q, last_q;
  logic             tick;

  assign tick   = busy_q && (cnt_q == div_i);
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;
  assign busy_o = busy_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (abort_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (!busy_q) begin
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      last_q <= 1'b0;
      if (start_i) busy_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
      if (sck_q && last_q) begin
        busy_q <= 1'b0;
        last_q <= 1'b0;
      end else if (!sck_q && done_i) begin
        last_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_req_shift.sv
module spi_req_shift
  import spi_req_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          len_sel_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                din_i,
  input  logic                abort_i,
  input  logic                tx_load_i,
  input  logic [WORD_MAX-1:0] tx_data_i,
  input  logic                rx_read_i,
  output logic                dout_o,
  output logic                loaded_o,
  output logic                idle_o,
  output logic                done_o,
  output logic [WORD_MAX-1:0] rx_data_o,
  output logic                rx_full_o,
  output logic                tx_empty_o
);
  logic [CNT_W-1:0]    len, pad, bit_cnt_q;
  logic [WORD_MAX-1:0] tx_buf_q, tx_sh_q, rx_sh_q, rx_q, mask, rx_next;
  logic                tx_valid_q, loaded_q, rx_full_q, move;

  assign len     = len_bits(len_sel_i);
  assign pad     = CNT_W'(WORD_MAX) - len;
  assign mask    = ~({WORD_MAX{1'b1}} << len);
  assign idle_o  = (bit_cnt_q == '0);
  assign done_o  = rise_i && (bit_cnt_q == len - 1'b1);
  assign move    = idle_o && tx_valid_q && !loaded_q && !rise_i && !abort_i;
  assign rx_next = {rx_sh_q[WORD_MAX-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf_q   <= '0;
      tx_valid_q <= 1'b0;
    end else begin
      if (move) tx_valid_q <= 1'b0;
      if (tx_load_i) begin
        tx_buf_q   <= tx_data_i;
        tx_valid_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_q      <= '0;
      loaded_q  <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (rx_read_i) rx_full_q <= 1'b0;
      if (abort_i) begin
        bit_cnt_q <= '0;
        loaded_q  <= 1'b0;
      end else begin
        if (rise_i) begin
          rx_sh_q <= rx_next;
          if (done_o) begin
            bit_cnt_q <= '0;
            rx_q      <= rx_next & mask;
            rx_full_q <= 1'b1;
            loaded_q  <= 1'b0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        // trailing fall after the last bit must not shift the next word
        if (fall_i && !idle_o) tx_sh_q <= {tx_sh_q[WORD_MAX-2:0], 1'b0};
        if (move) begin
          tx_sh_q  <= tx_buf_q << pad;
          loaded_q <= 1'b1;
        end
      end
    end
  end

  assign dout_o     = tx_sh_q[WORD_MAX-1];
  assign loaded_o   = loaded_q;
  assign rx_data_o  = rx_q;
  assign rx_full_o  = rx_full_q;
  assign tx_empty_o = !tx_valid_q;
endmodule

// File: rtl/spi_req_port.sv
module spi_req_port
  import spi_req_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic [1:0]          len_sel_i,
  input  logic [DIV_W-1:0]    clk_div_i,
  input  logic [1:0]          req_en_i,
  input  logic [WORD_MAX-1:0] tx_data_i,
  input  logic                tx_load_i,
  output logic                tx_empty_o,
  output logic [WORD_MAX-1:0] rx_data_o,
  output logic                rx_full_o,
  input  logic                rx_read_i,
  output logic                bus_err_o,
  input  logic                err_clr_i,
  input  logic                sck_i,
  output logic                sck_o,
  output logic                sck_oe_o,
  input  logic                mosi_i,
  output logic                mosi_o,
  output logic                mosi_oe_o,
  input  logic                miso_i,
  output logic                miso_o,
  output logic                miso_oe_o,
  input  logic                ss_ni,
  input  logic                req_ni,
  output logic                req_no,
  output logic                req_oe_o
);
  logic [3:0] sync_q;
  logic       sck_s, mosi_s, ss_s, req_s, sck_d_q;
  logic       err_q, armed_q, req_q, req_oe_q;
  logic       m_rise, m_fall, m_busy, s_rise, s_fall, rise, fall, din;
  logic       start, done, loaded, idle, dout, slave_ready;

  spi_req_sync #(
    .N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, mosi_i, ss_ni, req_ni}),
    .q_o   (sync_q)
  );
  assign {sck_s, mosi_s, ss_s, req_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else sck_d_q <= sck_s;
  end

  assign s_rise = !master_i && !ss_s && !err_q && sck_s && !sck_d_q;
  assign s_fall = !master_i && !ss_s && !err_q && !sck_s && sck_d_q;
  assign rise   = master_i ? m_rise : s_rise;
  assign fall   = master_i ? m_fall : s_fall;
  assign din    = master_i ? miso_i : mosi_s;

  assign start = master_i && !m_busy && idle && loaded && armed_q
               && !req_s && !rx_full_o && !err_q;

  spi_req_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (clk_div_i),
    .start_i(start),
    .abort_i(err_q || !master_i),
    .done_i (done),
    .busy_o (m_busy),
    .sck_o  (sck_o),
    .rise_o (m_rise),
    .fall_o (m_fall)
  );

  spi_req_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_sel_i (len_sel_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .din_i     (din),
    .abort_i   (err_q),
    .tx_load_i (tx_load_i),
    .tx_data_i (tx_data_i),
    .rx_read_i (rx_read_i),
    .dout_o    (dout),
    .loaded_o  (loaded),
    .idle_o    (idle),
    .done_o    (done),
    .rx_data_o (rx_data_o),
    .rx_full_o (rx_full_o),
    .tx_empty_o(tx_empty_o)
  );

  assign slave_ready = !master_i && idle && loaded && !rx_full_o && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      armed_q  <= 1'b0;
      req_q    <= 1'b1;
      req_oe_q <= 1'b0;
    end else begin
      if (master_i && !ss_s) err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
      // re-arm only on a high level of the remote request
      if (req_s) armed_q <= 1'b1;
      else if (start) armed_q <= 1'b0;
      req_q    <= !slave_ready;
      req_oe_q <= !master_i && (req_en_i != 2'b00);
    end
  end

  assign bus_err_o = err_q;
  assign sck_oe_o  = m_busy;
  assign mosi_o    = dout;
  assign mosi_oe_o = master_i;
  assign miso_o    = dout;
  assign miso_oe_o = !master_i && !ss_s;
  assign req_no    = req_q;
  assign req_oe_o  = req_oe_q;
endmodule

// File: rtl/spi_req_port_chk.sv
module spi_req_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic master_i,
  input logic ss_ni,
  input logic err_clr_i,
  input logic tx_load_i,
  input logic sck_o,
  input logic sck_oe_o,
  input logic miso_oe_o,
  input logic req_oe_o,
  input logic bus_err_o,
  input logic tx_empty_o,
  input logic rx_full_o
);
  a_r2_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_oe_o |-> !sck_o);

  a_r3_legal_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_oe_o) |-> $past(master_i) && !$past(bus_err_o) && !$past(rx_full_o));

  a_r5_miso_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_ni && $past(ss_ni) && $past(ss_ni, 2) |-> !miso_oe_o);

  a_r7_req_released_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i && $past(master_i) |-> !req_oe_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o && !err_clr_i |=> bus_err_o);

  a_r8_err_stops_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o && $past(bus_err_o) |-> !sck_oe_o);

  a_r9_load_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> !tx_empty_o);
endmodule

bind spi_req_port spi_req_port_chk u_chk (.*);

// File: tb/spi_req_port_bench.sv
`timescale 1ns/1ps
module spi_req_port_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        master_i = 1'b1;
  logic [1:0]  len_sel_i = 2'b00, req_en_i = 2'b11;
  logic [7:0]  clk_div_i = 8'd1;
  logic [23:0] tx_data_i = '0, rx_data_o;
  logic        tx_load_i = 0, rx_read_i = 0, err_clr_i = 0;
  logic        tx_empty_o, rx_full_o, bus_err_o;
  logic        sck_i = 0, mosi_i = 0, miso_i = 0, ss_ni = 1, req_ni = 1;
  logic        sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, req_no, req_oe_o;

  int n_chk = 0, n_err = 0, cyc = 0, hi_cnt = 0;
  logic [23:0] rx_q[$], mosi_q[$];
  logic [23:0] bs_out = '0, bs_in = '0;
  int bs_len = 8, bs_cnt = 0;
  bit rxf_d = 0;

  always #2.5 clk_i = ~clk_i;

  spi_req_port u_spi_req_port (.*);

  function automatic logic [23:0] lmask(input int n);
    return ~(24'hFFFFFF << n);
  endfunction

  function automatic int nbits(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 24;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // watchdog
  always @(negedge clk_i) begin
    cyc++;
    if (sck_o) hi_cnt++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // monitor: received words
  always @(negedge clk_i) begin
    if (rx_full_o && !rxf_d) begin
      if (rx_q.size() == 0) chk(0, "R9 unexpected rx word", rx_data_o, 0);
      else begin
        logic [23:0] e;
        e = rx_q.pop_front();
        chk(rx_data_o == e, "R1 rx word", rx_data_o, e);
      end
    end
    rxf_d = rx_full_o;
  end

  // remote slave model for master mode
  always @(posedge sck_o) if (master_i) begin
    bs_in = {bs_in[22:0], mosi_o};
    bs_cnt++;
    if (bs_cnt == bs_len) begin
      logic [23:0] e;
      bs_cnt = 0;
      e = (mosi_q.size() != 0) ? mosi_q.pop_front() : 24'hX;
      chk((bs_in & lmask(bs_len)) == e, "R1 mosi word", bs_in & lmask(bs_len), e);
    end
  end
  always @(negedge sck_o) if (master_i) begin
    bs_out = bs_out << 1;
    miso_i = bs_out[bs_len-1];
  end

  task automatic load(input logic [23:0] w);
    tx_data_i = w; tx_load_i = 1; cyc_wait(1); tx_load_i = 0;
  endtask

  task automatic read_rx();
    rx_read_i = 1; cyc_wait(1); rx_read_i = 0; cyc_wait(1);
    chk(rx_full_o == 0, "R9 rx_full cleared", rx_full_o, 0);
  endtask

  task automatic arm_slave(input logic [23:0] sw);
    bs_len = nbits(len_sel_i); bs_cnt = 0; bs_out = sw; miso_i = sw[bs_len-1];
  endtask

  task automatic master_word(input logic [1:0] ls, input logic [7:0] dv,
                             input logic [23:0] tw, input logic [23:0] sw);
    int n;
    len_sel_i = ls; clk_div_i = dv; n = nbits(ls);
    load(tw);
    mosi_q.push_back(tw & lmask(n));
    rx_q.push_back(sw & lmask(n));
    arm_slave(sw);
    cyc_wait(10);
    chk(sck_oe_o == 0, "R3 no start while req high", sck_oe_o, 0);
    hi_cnt = 0;
    req_ni = 0;
    while (!rx_full_o) @(negedge clk_i);
    while (sck_oe_o) @(negedge clk_i);
    cyc_wait(1);
    chk(hi_cnt == n * (dv + 1), "R2 sck high cycles", hi_cnt, n * (dv + 1));
    chk(sck_o == 0, "R2 sck idles low", sck_o, 0);
    req_ni = 1;
    read_rx();
  endtask

  task automatic slave_word(input logic [1:0] ls, input logic [23:0] tw,
                            input logic [23:0] mw, input bit noise);
    int n;
    logic [23:0] got;
    len_sel_i = ls; n = nbits(ls); got = '0;
    load(tw);
    rx_q.push_back(mw & lmask(n));
    while (req_no) @(negedge clk_i);
    chk(req_no == 0, "R6 request asserted", req_no, 0);
    if (noise) begin
      for (int k = 0; k < 5; k++) begin
        mosi_i = k[0]; sck_i = 1; cyc_wait(6); sck_i = 0; cyc_wait(6);
      end
      chk(miso_oe_o == 0, "R5 miso released", miso_oe_o, 0);
      chk(req_no == 0, "R5 no word started while deselected", req_no, 0);
    end
    ss_ni = 0; cyc_wait(4);
    for (int i = 0; i < n; i++) begin
      mosi_i = mw[n-1-i];
      cyc_wait(8);
      got[n-1-i] = miso_o;
      sck_i = 1; cyc_wait(8);
      if (i == 0) begin
        chk(req_no == 1, "R6 request dropped after first edge", req_no, 1);
        chk(miso_oe_o == 1, "R5 miso driven when selected", miso_oe_o, 1);
      end
      sck_i = 0;
    end
    cyc_wait(8); ss_ni = 1; cyc_wait(4);
    chk(got == (tw & lmask(n)), "R1 miso word", got, tw & lmask(n));
    chk(rx_full_o == 1, "R9 rx_full set", rx_full_o, 1);
    read_rx();
  endtask

  initial begin
    cyc_wait(3);
    chk(tx_empty_o == 1, "R10 tx_empty", tx_empty_o, 1);
    chk(rx_full_o == 0, "R10 rx_full", rx_full_o, 0);
    chk(bus_err_o == 0, "R10 bus_err", bus_err_o, 0);
    chk(sck_oe_o == 0, "R10 sck_oe", sck_oe_o, 0);
    chk(req_oe_o == 0, "R7 R10 req_oe in reset", req_oe_o, 0);
    chk(req_no == 1, "R10 req_no", req_no, 1);
    rst_ni = 1; cyc_wait(4);

    // master words, various lengths and dividers
    master_word(2'b00, 8'd1, 24'h0000A5, 24'h00003C);
    master_word(2'b01, 8'd2, 24'h00C3E1, 24'h008001);
    master_word(2'b10, 8'd0, 24'h9ABCDE, 24'hF0F00F);
    master_word(2'b11, 8'd3, 24'h123456, 24'h6DB6DB);

    // R4 / R9: double buffering and re-arm
    len_sel_i = 2'b00; clk_div_i = 8'd1;
    load(24'h81); cyc_wait(3);
    load(24'h7E); cyc_wait(2);
    chk(tx_empty_o == 0, "R9 second word held in buffer", tx_empty_o, 0);
    mosi_q.push_back(24'h81); rx_q.push_back(24'h55);
    arm_slave(24'h55);
    req_ni = 0;
    while (!rx_full_o) @(negedge clk_i);
    while (sck_oe_o) @(negedge clk_i);
    read_rx(); cyc_wait(3);
    chk(tx_empty_o == 1, "R9 buffer moved to shifter", tx_empty_o, 1);
    hi_cnt = 0; cyc_wait(40);
    chk(sck_oe_o == 0 && hi_cnt == 0, "R4 no restart on held request", hi_cnt, 0);
    mosi_q.push_back(24'h7E); rx_q.push_back(24'hAA);
    arm_slave(24'hAA);
    req_ni = 1; cyc_wait(4); req_ni = 0;
    while (!rx_full_o) @(negedge clk_i);
    while (sck_oe_o) @(negedge clk_i);
    req_ni = 1;
    read_rx();

    // R8: select conflict aborts a word
    len_sel_i = 2'b10; clk_div_i = 8'd5;
    load(24'hFFFFFF); arm_slave(24'h0);
    req_ni = 0;
    while (!sck_oe_o) @(negedge clk_i);
    cyc_wait(20);
    ss_ni = 0; cyc_wait(5);
    chk(bus_err_o == 1, "R8 bus error set", bus_err_o, 1);
    chk(sck_oe_o == 0, "R8 word aborted", sck_oe_o, 0);
    ss_ni = 1; req_ni = 1; cyc_wait(6);
    chk(bus_err_o == 1, "R8 bus error sticky", bus_err_o, 1);
    err_clr_i = 1; cyc_wait(1); err_clr_i = 0; cyc_wait(2);
    chk(bus_err_o == 0, "R8 bus error cleared", bus_err_o, 0);
    chk(rx_full_o == 0, "R8 no word from aborted transfer", rx_full_o, 0);
    bs_cnt = 0;
    master_word(2'b00, 8'd1, 24'h00004B, 24'h0000D2);

    // slave mode
    master_i = 0; req_en_i = 2'b11; cyc_wait(3);
    chk(req_oe_o == 1, "R7 req driven in slave mode", req_oe_o, 1);
    slave_word(2'b00, 24'h000096, 24'h00005A, 1'b0);
    slave_word(2'b01, 24'h001234, 24'h00BEEF, 1'b0);
    slave_word(2'b10, 24'hA1B2C3, 24'h3C5A96, 1'b1);
    req_en_i = 2'b00; cyc_wait(3);
    chk(req_oe_o == 0, "R7 req released with enables clear", req_oe_o, 0);
    req_en_i = 2'b10; master_i = 1; cyc_wait(3);
    chk(req_oe_o == 0, "R7 req released in master mode", req_oe_o, 0);
    chk(rx_q.size() == 0 && mosi_q.size() == 0, "R1 scoreboard drained",
        rx_q.size() + mosi_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule